// File: doc/BRIEF.md
# Self-Starting Skip-Sequence Counter

This block is a three-bit counter whose state is its only output. The state bits are named C (most significant), B and A (least significant). It does not count in binary order. Each step visits five codes in a fixed loop: 000, 010, 011, 101, 110, and then 000 again. A step happens on a rising clock edge while the count input is high. When the count input is low, the state does not change.

The three codes outside the loop are 001, 100 and 111. Each of them has a fixed successor, so a state left unknown at power-up always returns to the loop after a few count steps. Some logic or an unclocked path may also corrupt the state into one of these codes; the same recovery applies. An active-low reset is sampled on the clock edge. It puts the counter at 000, and it takes priority over counting.

A small control module turns reset and count into two strobes: clear and step. A datapath module holds the register and the next-code function. The next-code function is a separate combinational module, so all eight codes can be checked directly.

Top module: `ssc_counter`

## Requirements
- R1: When rstN is low at a rising clock edge, the state becomes 000 after that edge, whatever the value of countEn.
- R2: When rstN is high and countEn is low at a rising edge, the state keeps its value.
- R3: With countEn high, the loop codes step 000→010→011→101→110→000. A loop code never moves to a code outside the loop.
- R4: With countEn high, the unused code 001 steps to 111.
- R5: With countEn high, the unused code 100 steps to 011.
- R6: With countEn high, the unused code 111 steps to 101.
- R7: On every count step, the new bit C (state[2]) equals the old bit A (state[0]).
- R8: From any of the eight codes, at most two count steps reach a loop code (000, 010, 011, 101 or 110).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rstN | input | 1 | Synchronous reset, active low, forces 000 |
| countEn | input | 1 | Advances the state one step when high |
| state | output | 3 | Present code, {C,B,A} |

## Verification
The first stimulus is a table of count-enable patterns applied after reset. It runs the loop twice, with gaps where counting stops. A wrong successor shows up as a wrong code, and a hold that leaks shows up as a change during a gap. A reset that arrives while counting must win over the count. The next-code function is then driven directly with each of the eight codes. This separates errors on the three recovery paths from errors in the main loop, and it confirms the two-step bound by applying the function twice to each code.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int StateW = 3;
  typedef logic [StateW-1:0] code_t;

  localparam code_t CodeS0 = 3'b000;
  localparam code_t CodeS1 = 3'b010;
  localparam code_t CodeS2 = 3'b011;
  localparam code_t CodeS3 = 3'b101;
  localparam code_t CodeS4 = 3'b110;
  localparam code_t CodeX1 = 3'b001;
  localparam code_t CodeX4 = 3'b100;
  localparam code_t CodeX7 = 3'b111;

  typedef struct packed {
    logic clear;
    logic step;
  } strobe_t;
endpackage

// File: rtl/ssc_next.sv
module ssc_next
  import ssc_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  always_comb begin
    unique case (cur)
      CodeS0:  nxt = CodeS1;
      CodeS1:  nxt = CodeS2;
      CodeS2:  nxt = CodeS3;
      CodeS3:  nxt = CodeS4;
      CodeS4:  nxt = CodeS0;
      CodeX1:  nxt = CodeX7;
      CodeX4:  nxt = CodeS2;
      CodeX7:  nxt = CodeS3;
      default: nxt = CodeS0;
    endcase
  end
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
(
  input  logic    rstN,
  input  logic    countEn,
  output strobe_t strobe
);
  always_comb begin
    strobe.clear = !rstN;
    strobe.step  = rstN && countEn;
  end
endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
(
  input  logic    clk,
  input  strobe_t strobe,
  output code_t   state
);
  code_t stateQ;
  code_t nextCode;

  ssc_next u_next (
    .cur (stateQ),
    .nxt (nextCode)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear)     stateQ <= CodeS0;
    else if (strobe.step) stateQ <= nextCode;
  end

  assign state = stateQ;
endmodule

// File: rtl/ssc_counter.sv
module ssc_counter
  import ssc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countEn,
  output logic [2:0] state
);
  strobe_t strobe;

  ssc_ctrl u_ctrl (
    .rstN    (rstN),
    .countEn (countEn),
    .strobe  (strobe)
  );

  ssc_datapath u_dp (
    .clk    (clk),
    .strobe (strobe),
    .state  (state)
  );
endmodule

// File: rtl/ssc_counter_chk.sv
module ssc_counter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       countEn,
  input logic [2:0] state
);
  logic       armed = 1'b0;
  logic [1:0] outsideSteps;
  logic       inLoop;

  assign inLoop = (state == 3'b000) || (state == 3'b010) || (state == 3'b011) ||
                  (state == 3'b101) || (state == 3'b110);

  always_ff @(posedge clk) armed <= 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)                    outsideSteps <= 2'd0;
    else if (inLoop)              outsideSteps <= 2'd0;
    else if (countEn)             outsideSteps <= outsideSteps + 2'd1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    !rstN |=> state == 3'b000);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(state));

  p_loop_closed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && inLoop) |=> inLoop);

  p_c_from_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    countEn |=> state[2] == $past(state[0]));

  p_recover_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    outsideSteps != 2'd3);
endmodule

bind ssc_counter ssc_counter_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .countEn (countEn),
  .state   (state)
);

// File: tb/ssc_counter_tb.sv
module ssc_counter_tb;
  import ssc_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countEn = 1'b0;
  logic [2:0] state;
  code_t      probeCur;
  code_t      probeNxt;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  ssc_counter u_dut (.clk(clk), .rstN(rstN), .countEn(countEn), .state(state));
  ssc_next u_nsl (.cur(probeCur), .nxt(probeNxt));

  // {countEn, expected state after the edge}
  localparam logic [3:0] VEC [0:13] = '{
    4'b1_010, 4'b1_011, 4'b0_011, 4'b1_101, 4'b1_110, 4'b0_110, 4'b0_110,
    4'b1_000, 4'b1_010, 4'b1_011, 4'b1_101, 4'b1_110, 4'b1_000, 4'b0_000
  };

  // successor of each code, from R3..R6
  localparam logic [2:0] SUCC [0:7] = '{
    3'b010, 3'b111, 3'b011, 3'b101, 3'b011, 3'b110, 3'b000, 3'b101
  };

  function automatic bit isLoop(logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b011 || c == 3'b101 || c == 3'b110;
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    probeCur = 3'b000;
    rstN = 1'b0;
    countEn = 1'b1;
    tick();
    tick();
    check("R1 reset with count high", state, 3'b000);
    rstN = 1'b1;

    // R2 R3: table walk
    for (int i = 0; i < 14; i++) begin
      countEn = VEC[i][3];
      tick();
      check(VEC[i][3] ? "R3 loop step" : "R2 hold", state, VEC[i][2:0]);
    end

    // R1: reset mid-sequence overrides count
    countEn = 1'b1;
    tick();
    tick();
    check("R3 step before reset", state, 3'b011);
    rstN = 1'b0;
    tick();
    check("R1 reset overrides count", state, 3'b000);
    rstN = 1'b1;
    countEn = 1'b0;
    tick();
    check("R2 hold after reset", state, 3'b000);

    // next-code function for all eight codes
    for (int c = 0; c < 8; c++) begin
      probeCur = 3'(c);
      #1;
      case (c)
        1: check("R4 code 001", probeNxt, SUCC[c]);
        4: check("R5 code 100", probeNxt, SUCC[c]);
        7: check("R6 code 111", probeNxt, SUCC[c]);
        default: check("R3 loop code", probeNxt, SUCC[c]);
      endcase
      check("R7 C follows A", {2'b00, probeNxt[2]}, {2'b00, probeCur[0]});
    end

    // R8: two applications reach the loop
    for (int c = 0; c < 8; c++) begin
      logic [2:0] first;
      probeCur = 3'(c);
      #1;
      first = probeNxt;
      probeCur = first;
      #1;
      nChecks++;
      if (!isLoop(first) && !isLoop(probeNxt)) begin
        nFails++;
        $display("FAIL R8 from %0d: got %b expected a loop code", c, probeNxt);
      end
    end

    report();
  end
endmodule